// File: doc/BRIEF.md
# ASID-Invalidatable Associative TLB Array

This block is the storage and lookup half of a small fully-associative translation cache. Each entry maps one virtual page pair, named by its upper page number bits and an 8-bit address-space identifier, to two physical frames. One frame serves the even page and one the odd page, and each frame carries its own cache attribute, dirty and valid bits. A single global bit makes the entry match under any address-space identifier. Every entry also has a hardware invalidate bit. While that bit is set, the entry cannot be hit by a probe and reads back in a fixed empty form.

A command port takes an operation code and an index. The five operations are indexed write, indexed read, probe, invalidate by address-space identifier, and invalidate everything. Write, probe and invalidate-by-identifier all take their key from a held page-tag register, which software loads through a masked write port. Every legal command produces a one-cycle done pulse, and the read and probe results are registered together with that pulse. The page size is fixed at 4 KB, so the page-mask read-back is always zero.

Top module: `tlb_inv_array`

## Requirements
- R1: A synchronous active-high reset leaves every entry invalidated, clears the tag register, and drives done, the probe index, the miss flag and all read-back words to zero.
- R2: A tag-register write keeps bits 31:13 (page tag) and 7:0 (identifier) of the data and forces bits 12:11 and 9:8 to zero. Bit 10, the invalidate flag, is kept only when the 2-bit invalidate-support input is 2 or 3, and is zeroed otherwise. The result is visible on `ehi_q` one cycle later.
- R3: An indexed write while tag bit 10 is 1 marks the entry invalidated and nothing else. Afterwards that entry reads back in the empty form and no probe can hit it.
- R4: An indexed write while tag bit 10 is 0 clears the entry's invalidate bit and loads the page tag, the identifier, both halves' PFN, cache attribute, dirty and valid bits, and a global bit equal to the AND of bit 0 of both EntryLo inputs. A read of that entry returns the page tag in bits 31:13 and the identifier in bits 7:0. Each EntryLo word returns G in bit 0, V in bit 1, D in bit 2, the cache attribute in bits 5:3 and the PFN from bit 6 upward, with the same G in both words and a page mask of zero.
- R5: A read of an invalidated entry returns a tag word with only bit 10 set, and zero for the page mask and both EntryLo words.
- R6: A probe hits an entry whose invalidate bit is 0, whose page tag equals the tag-register page tag, and which is either global or has an identifier equal to the tag-register identifier. When several entries match, the lowest index is reported and the miss flag is cleared.
- R7: A probe with no matching entry sets the miss flag and leaves the probe index at its previous value.
- R8: Invalidate-by-identifier sets the invalidate bit of every non-global entry whose identifier equals the tag-register identifier, whatever its page tag. Global entries and entries with other identifiers are left untouched.
- R9: Invalidate-all sets the invalidate bit of every entry, including global ones.
- R10: Each of the five operations raises done for exactly one cycle, in the cycle after the command is sampled. Read, probe and invalidate results are already in place in that cycle.
- R11: A write or read whose index is NUM_ENTRIES or more changes no entry and no read-back output, and still produces done.
- R12: The operation codes are 1 write, 2 read, 3 probe, 4 invalidate-by-identifier and 5 invalidate-all. Codes 0, 6 and 7 do nothing and produce no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ehi_wr_en | input | 1 | Load the tag register from `ehi_wr_data` |
| ehi_wr_data | input | 32 | Raw tag-register value |
| inv_support | input | 2 | Invalidate-support level; 2 or more keeps the flag bit |
| lo0_in | input | PFN_W+6 | Even-page EntryLo value for writes |
| lo1_in | input | PFN_W+6 | Odd-page EntryLo value for writes |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code |
| cmd_index | input | $clog2(NUM_ENTRIES)+1 | Entry index for write and read |
| ehi_q | output | 32 | Current masked tag register |
| done | output | 1 | Command completion pulse |
| probe_idx | output | $clog2(NUM_ENTRIES) | Index of the last probe hit |
| probe_miss | output | 1 | Last probe found no entry |
| rd_hi | output | 32 | Read-back tag word |
| rd_pagemask | output | 32 | Read-back page mask (always zero) |
| rd_lo0 | output | 32 | Read-back even-page EntryLo |
| rd_lo1 | output | 32 | Read-back odd-page EntryLo |

## Verification
A command presented before a rising edge produces done after that edge. The read words, the probe index and miss flag, and the invalidate bits all settle at that same edge, so every result is due one cycle after its command. The driver pushes the expected result for each command when it issues it. The monitor compares at the falling edge of each cycle where done is high, so a late or missing pulse shows up as a mismatch or an empty queue. Tag-register writes are checked at the falling edge one cycle after the write strobe, and illegal codes are checked for an absent done at that same distance.

// File: rtl/tlb_inv_pkg.sv
package tlb_inv_pkg;

  localparam int REG_W       = 32;
  localparam int EHI_INV_BIT = 10;
  localparam int EHI_VPN_LSB = 13;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_WRITE    = 3'd1,
    OP_READ     = 3'd2,
    OP_PROBE    = 3'd3,
    OP_INV_ASID = 3'd4,
    OP_INV_ALL  = 3'd5
  } tlb_op_e;

endpackage

// File: rtl/tlb_ehi_reg.sv
module tlb_ehi_reg
  import tlb_inv_pkg::*;
#(
  parameter int VPN2_W = 19,
  parameter int ASID_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       inv_support,
  output logic [REG_W-1:0] ehi_q
);

  logic [REG_W-1:0] keep_mask;

  always_comb begin
    keep_mask = '0;
    keep_mask[EHI_VPN_LSB +: VPN2_W] = '1;
    keep_mask[ASID_W-1:0]            = '1;
    keep_mask[EHI_INV_BIT]           = (inv_support >= 2'd2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ehi_q <= '0;
    end else if (wr_en) begin
      ehi_q <= wr_data & keep_mask;
    end
  end

endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int NUM_ENTRIES = 16,
  parameter int VPN2_W      = 19,
  parameter int ASID_W      = 8,
  parameter int PFN_W       = 20,
  parameter int IDX_W       = 4,
  parameter int HALF_W      = PFN_W + 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic                   wr_inv,
  input  logic [VPN2_W-1:0]      wr_vpn,
  input  logic [ASID_W-1:0]      wr_asid,
  input  logic                   wr_g,
  input  logic [HALF_W-1:0]      wr_half0,
  input  logic [HALF_W-1:0]      wr_half1,
  input  logic                   inv_asid_en,
  input  logic                   inv_all_en,
  input  logic [ASID_W-1:0]      cur_asid,
  input  logic [VPN2_W-1:0]      probe_vpn,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic                   rd_inv,
  output logic [VPN2_W-1:0]      rd_vpn,
  output logic [ASID_W-1:0]      rd_asid,
  output logic                   rd_g,
  output logic [HALF_W-1:0]      rd_half0,
  output logic [HALF_W-1:0]      rd_half1,
  output logic [NUM_ENTRIES-1:0] inv_vec,
  output logic [NUM_ENTRIES-1:0] hit_vec
);

  // Tag fields need parallel compare and are held in flops.
  logic [VPN2_W-1:0] vpn_q  [NUM_ENTRIES];
  logic [ASID_W-1:0] asid_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] g_q;

  // Frame data is only touched through the indexed port: RAM-style array.
  logic [HALF_W-1:0] half0_mem [NUM_ENTRIES];
  logic [HALF_W-1:0] half1_mem [NUM_ENTRIES];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic this_wr;
    logic asid_kill;
    assign this_wr   = wr_en && (wr_idx == IDX_W'(e));
    assign asid_kill = inv_asid_en && !g_q[e] && (asid_q[e] == cur_asid);

    always_ff @(posedge clk) begin
      if (rst) begin
        inv_vec[e] <= 1'b1;
        vpn_q[e]   <= '0;
        asid_q[e]  <= '0;
        g_q[e]     <= 1'b0;
      end else if (this_wr) begin
        inv_vec[e] <= wr_inv;
        if (!wr_inv) begin
          vpn_q[e]  <= wr_vpn;
          asid_q[e] <= wr_asid;
          g_q[e]    <= wr_g;
        end
      end else if (inv_all_en || asid_kill) begin
        inv_vec[e] <= 1'b1;
      end
    end

    assign hit_vec[e] = !inv_vec[e] && (vpn_q[e] == probe_vpn) &&
                        (g_q[e] || (asid_q[e] == cur_asid));
  end

  always_ff @(posedge clk) begin
    if (wr_en && !wr_inv) begin
      half0_mem[wr_idx] <= wr_half0;
      half1_mem[wr_idx] <= wr_half1;
    end
  end

  assign rd_inv   = inv_vec[rd_idx];
  assign rd_vpn   = vpn_q[rd_idx];
  assign rd_asid  = asid_q[rd_idx];
  assign rd_g     = g_q[rd_idx];
  assign rd_half0 = half0_mem[rd_idx];
  assign rd_half1 = half1_mem[rd_idx];

endmodule

// File: rtl/tlb_probe_enc.sv
module tlb_probe_enc #(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = 4
) (
  input  logic [NUM_ENTRIES-1:0] hit_vec,
  output logic                   any_hit,
  output logic [IDX_W-1:0]       hit_idx
);

  always_comb begin
    hit_idx = '0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
      if (hit_vec[e]) hit_idx = IDX_W'(e);
    end
  end

  assign any_hit = |hit_vec;

endmodule

// File: rtl/tlb_inv_array.sv
module tlb_inv_array
  import tlb_inv_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int VPN2_W      = 19,
  parameter int ASID_W      = 8,
  parameter int PFN_W       = 20
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 ehi_wr_en,
  input  logic [31:0]                          ehi_wr_data,
  input  logic [1:0]                           inv_support,
  input  logic [PFN_W+5:0]                     lo0_in,
  input  logic [PFN_W+5:0]                     lo1_in,
  input  logic                                 cmd_valid,
  input  logic [2:0]                           cmd_op,
  input  logic [$clog2(NUM_ENTRIES):0]         cmd_index,
  output logic [31:0]                          ehi_q,
  output logic                                 done,
  output logic [$clog2(NUM_ENTRIES)-1:0]       probe_idx,
  output logic                                 probe_miss,
  output logic [31:0]                          rd_hi,
  output logic [31:0]                          rd_pagemask,
  output logic [31:0]                          rd_lo0,
  output logic [31:0]                          rd_lo1
);

  localparam int IDX_W     = $clog2(NUM_ENTRIES);
  localparam int CMD_IDX_W = IDX_W + 1;
  localparam int HALF_W    = PFN_W + 5;

  logic in_range;
  logic is_write, is_read, is_probe, is_inv_asid, is_inv_all, is_legal;

  assign in_range    = cmd_index < CMD_IDX_W'(NUM_ENTRIES);
  assign is_write    = cmd_valid && (cmd_op == OP_WRITE);
  assign is_read     = cmd_valid && (cmd_op == OP_READ);
  assign is_probe    = cmd_valid && (cmd_op == OP_PROBE);
  assign is_inv_asid = cmd_valid && (cmd_op == OP_INV_ASID);
  assign is_inv_all  = cmd_valid && (cmd_op == OP_INV_ALL);
  assign is_legal    = is_write | is_read | is_probe | is_inv_asid | is_inv_all;

  tlb_ehi_reg #(.VPN2_W(VPN2_W), .ASID_W(ASID_W)) u_ehi (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (ehi_wr_en),
    .wr_data    (ehi_wr_data),
    .inv_support(inv_support),
    .ehi_q      (ehi_q)
  );

  logic [VPN2_W-1:0] key_vpn;
  logic [ASID_W-1:0] key_asid;
  logic              key_inv;
  assign key_vpn  = ehi_q[EHI_VPN_LSB +: VPN2_W];
  assign key_asid = ehi_q[ASID_W-1:0];
  assign key_inv  = ehi_q[EHI_INV_BIT];

  // EntryLo inputs: bit0 G, bit1 V, bit2 D, bits5:3 C, PFN from bit 6.
  // Stored half layout drops G: {pfn, c, d, v}.
  logic [HALF_W-1:0] wr_half0, wr_half1;
  logic              wr_g;
  assign wr_half0 = lo0_in[PFN_W+5:1];
  assign wr_half1 = lo1_in[PFN_W+5:1];
  assign wr_g     = lo0_in[0] & lo1_in[0];

  logic                   rd_inv_w, rd_g_w;
  logic [VPN2_W-1:0]      rd_vpn_w;
  logic [ASID_W-1:0]      rd_asid_w;
  logic [HALF_W-1:0]      rd_half0_w, rd_half1_w;
  logic [NUM_ENTRIES-1:0] inv_vec, hit_vec;

  tlb_entry_store #(
    .NUM_ENTRIES(NUM_ENTRIES), .VPN2_W(VPN2_W), .ASID_W(ASID_W),
    .PFN_W(PFN_W), .IDX_W(IDX_W), .HALF_W(HALF_W)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (is_write && in_range),
    .wr_idx     (cmd_index[IDX_W-1:0]),
    .wr_inv     (key_inv),
    .wr_vpn     (key_vpn),
    .wr_asid    (key_asid),
    .wr_g       (wr_g),
    .wr_half0   (wr_half0),
    .wr_half1   (wr_half1),
    .inv_asid_en(is_inv_asid),
    .inv_all_en (is_inv_all),
    .cur_asid   (key_asid),
    .probe_vpn  (key_vpn),
    .rd_idx     (cmd_index[IDX_W-1:0]),
    .rd_inv     (rd_inv_w),
    .rd_vpn     (rd_vpn_w),
    .rd_asid    (rd_asid_w),
    .rd_g       (rd_g_w),
    .rd_half0   (rd_half0_w),
    .rd_half1   (rd_half1_w),
    .inv_vec    (inv_vec),
    .hit_vec    (hit_vec)
  );

  logic             any_hit;
  logic [IDX_W-1:0] first_hit;

  tlb_probe_enc #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_enc (
    .hit_vec(hit_vec),
    .any_hit(any_hit),
    .hit_idx(first_hit)
  );

  logic [31:0] fmt_hi, fmt_lo0, fmt_lo1;

  always_comb begin
    fmt_hi  = '0;
    fmt_lo0 = '0;
    fmt_lo1 = '0;
    if (rd_inv_w) begin
      fmt_hi[EHI_INV_BIT] = 1'b1;
    end else begin
      fmt_hi[EHI_VPN_LSB +: VPN2_W] = rd_vpn_w;
      fmt_hi[ASID_W-1:0]            = rd_asid_w;
      fmt_lo0[HALF_W:0]             = {rd_half0_w, rd_g_w};
      fmt_lo1[HALF_W:0]             = {rd_half1_w, rd_g_w};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      probe_idx   <= '0;
      probe_miss  <= 1'b0;
      rd_hi       <= '0;
      rd_pagemask <= '0;
      rd_lo0      <= '0;
      rd_lo1      <= '0;
    end else begin
      done <= is_legal;
      if (is_probe) begin
        probe_miss <= !any_hit;
        if (any_hit) probe_idx <= first_hit;
      end
      if (is_read && in_range) begin
        rd_hi       <= fmt_hi;
        rd_pagemask <= '0;
        rd_lo0      <= fmt_lo0;
        rd_lo1      <= fmt_lo1;
      end
    end
  end

endmodule

// File: rtl/tlb_inv_array_chk.sv
module tlb_inv_array_chk
  import tlb_inv_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cmd_valid,
  input logic [2:0]             cmd_op,
  input logic                   ehi_wr_en,
  input logic [1:0]             inv_support,
  input logic [31:0]            ehi_q,
  input logic                   done,
  input logic                   probe_miss,
  input logic [IDX_W-1:0]       probe_idx,
  input logic [31:0]            rd_hi,
  input logic [31:0]            rd_lo0,
  input logic [31:0]            rd_lo1,
  input logic [NUM_ENTRIES-1:0] inv_vec
);

  logic legal;
  assign legal = cmd_valid && (cmd_op >= 3'd1) && (cmd_op <= 3'd5);

  p_reset_all_invalid_r1: assert property (@(posedge clk)
    $past(rst) |-> (&inv_vec));

  p_flag_masked_r2: assert property (@(posedge clk) disable iff (rst)
    (ehi_wr_en && inv_support < 2'd2) |=> !ehi_q[EHI_INV_BIT]);

  p_empty_readback_r5: assert property (@(posedge clk) disable iff (rst)
    rd_hi[EHI_INV_BIT] |-> (rd_lo0 == '0 && rd_lo1 == '0));

  p_miss_keeps_idx_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_PROBE) |=> (!probe_miss || $stable(probe_idx)));

  p_asid_inv_only_sets_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_INV_ASID) |=> (($past(inv_vec) & ~inv_vec) == '0));

  p_inv_all_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_INV_ALL) |=> (&inv_vec));

  p_done_follows_r10: assert property (@(posedge clk) disable iff (rst)
    legal |=> done);

  p_no_done_illegal_r12: assert property (@(posedge clk) disable iff (rst)
    !legal |=> !done);

endmodule

bind tlb_inv_array tlb_inv_array_chk #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .ehi_wr_en  (ehi_wr_en),
  .inv_support(inv_support),
  .ehi_q      (ehi_q),
  .done       (done),
  .probe_miss (probe_miss),
  .probe_idx  (probe_idx),
  .rd_hi      (rd_hi),
  .rd_lo0     (rd_lo0),
  .rd_lo1     (rd_lo1),
  .inv_vec    (inv_vec)
);

// File: tb/tb_tlb_inv_array.sv
module tb_tlb_inv_array;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ehi_wr_en = 1'b0;
  logic [31:0] ehi_wr_data = '0;
  logic [1:0]  inv_support = 2'd2;
  logic [25:0] lo0_in = '0, lo1_in = '0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [4:0]  cmd_index = '0;
  logic [31:0] ehi_q, rd_hi, rd_pagemask, rd_lo0, rd_lo1;
  logic        done, probe_miss;
  logic [3:0]  probe_idx;

  tlb_inv_array dut (
    .clk(clk), .rst(rst), .ehi_wr_en(ehi_wr_en), .ehi_wr_data(ehi_wr_data),
    .inv_support(inv_support), .lo0_in(lo0_in), .lo1_in(lo1_in),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_index(cmd_index),
    .ehi_q(ehi_q), .done(done), .probe_idx(probe_idx), .probe_miss(probe_miss),
    .rd_hi(rd_hi), .rd_pagemask(rd_pagemask), .rd_lo0(rd_lo0), .rd_lo1(rd_lo1)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit summary_done = 0;

  typedef struct {
    string       req;
    bit          is_read;
    bit          is_probe;
    logic [31:0] hi, lo0, lo1;
    bit          miss;
    logic [3:0]  idx;
  } exp_t;

  exp_t sb_q[$];

  // Reference model state
  bit          m_inv [N];
  logic [18:0] m_vpn [N];
  logic [7:0]  m_asid[N];
  bit          m_g   [N];
  logic [25:0] m_lo0 [N];
  logic [25:0] m_lo1 [N];
  logic [31:0] m_ehi = '0;
  logic [31:0] last_hi = '0, last_lo0 = '0, last_lo1 = '0;
  logic [3:0]  last_idx = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Monitor: pops an expected item on every done pulse
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb_q.size() == 0) begin
        check(0, "R10", "unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(1, e.req, "done", 32'd1, 32'd1);
        if (e.is_read) begin
          check(rd_hi == e.hi, e.req, "rd_hi", rd_hi, e.hi);
          check(rd_lo0 == e.lo0, e.req, "rd_lo0", rd_lo0, e.lo0);
          check(rd_lo1 == e.lo1, e.req, "rd_lo1", rd_lo1, e.lo1);
          check(rd_pagemask == 32'd0, e.req, "rd_pagemask", rd_pagemask, 32'd0);
        end
        if (e.is_probe) begin
          check(probe_miss == e.miss, e.req, "probe_miss",
                {31'd0, probe_miss}, {31'd0, e.miss});
          check(probe_idx == e.idx, e.req, "probe_idx",
                {28'd0, probe_idx}, {28'd0, e.idx});
        end
      end
    end
  end

  // Tag register write: bit 10 kept only when support >= 2
  task automatic set_ehi(input logic [31:0] data, input logic [1:0] sup, input string req);
    logic [31:0] mask;
    mask = 32'hFFFF_E0FF | ((sup >= 2'd2) ? 32'h0000_0400 : 32'h0);
    @(negedge clk);
    ehi_wr_data = data; inv_support = sup; ehi_wr_en = 1'b1;
    @(negedge clk);
    ehi_wr_en = 1'b0;
    m_ehi = data & mask;
    check(ehi_q == m_ehi, req, "ehi_q", ehi_q, m_ehi);
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [4:0] idx, input string req);
    exp_t e;
    e.req = req; e.is_read = 0; e.is_probe = 0;
    e.hi = '0; e.lo0 = '0; e.lo1 = '0; e.miss = 0; e.idx = '0;
    case (op)
      3'd1: if (idx < N) begin
        if (m_ehi[10]) m_inv[idx] = 1;
        else begin
          m_inv[idx]  = 0;
          m_vpn[idx]  = m_ehi[31:13];
          m_asid[idx] = m_ehi[7:0];
          m_g[idx]    = lo0_in[0] & lo1_in[0];
          m_lo0[idx]  = {lo0_in[25:1], 1'b0};
          m_lo1[idx]  = {lo1_in[25:1], 1'b0};
        end
      end
      3'd2: begin
        e.is_read = 1;
        if (idx < N) begin
          if (m_inv[idx]) begin
            last_hi = 32'h0000_0400; last_lo0 = '0; last_lo1 = '0;
          end else begin
            last_hi  = {m_vpn[idx], 5'd0, m_asid[idx]};
            last_lo0 = {6'd0, m_lo0[idx] | 26'(m_g[idx])};
            last_lo1 = {6'd0, m_lo1[idx] | 26'(m_g[idx])};
          end
        end
        e.hi = last_hi; e.lo0 = last_lo0; e.lo1 = last_lo1;
      end
      3'd3: begin
        bit found;
        found = 0;
        e.is_probe = 1;
        for (int i = 0; i < N; i++) begin
          if (!found && !m_inv[i] && m_vpn[i] == m_ehi[31:13] &&
              (m_g[i] || m_asid[i] == m_ehi[7:0])) begin
            found = 1; last_idx = 4'(i);
          end
        end
        e.miss = !found; e.idx = last_idx;
      end
      3'd4: for (int i = 0; i < N; i++)
              if (!m_g[i] && m_asid[i] == m_ehi[7:0]) m_inv[i] = 1;
      3'd5: for (int i = 0; i < N; i++) m_inv[i] = 1;
      default: ;
    endcase
    sb_q.push_back(e);
    @(negedge clk);
    cmd_op = op; cmd_index = idx; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic write_entry(input logic [4:0] idx, input logic [18:0] vpn,
                             input logic [7:0] asid, input logic [25:0] l0,
                             input logic [25:0] l1, input bit flag, input string req);
    set_ehi({vpn, 2'b00, flag, 2'b00, asid}, 2'd2, "R2");
    lo0_in = l0; lo1_in = l1;
    do_cmd(3'd1, idx, req);
  endtask

  task automatic probe(input logic [18:0] vpn, input logic [7:0] asid, input string req);
    set_ehi({vpn, 5'd0, asid}, 2'd2, "R2");
    do_cmd(3'd3, 5'd0, req);
  endtask

  task automatic illegal_op(input logic [2:0] op);
    @(negedge clk);
    cmd_op = op; cmd_index = 5'd0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(done == 1'b0, "R12", "done on unused code", {31'd0, done}, 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    check(0, "R10", "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_inv[i] = 1; m_vpn[i] = '0; m_asid[i] = '0; m_g[i] = 0; m_lo0[i] = '0; m_lo1[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(done == 0 && probe_miss == 0 && probe_idx == 0, "R1", "ctl outputs",
          {probe_idx, 2'd0, probe_miss, done}, 32'd0);
    check(rd_hi == 0 && rd_lo0 == 0 && rd_lo1 == 0 && ehi_q == 0, "R1", "data outputs",
          rd_hi | rd_lo0 | rd_lo1 | ehi_q, 32'd0);
    do_cmd(3'd2, 5'd0, "R1");          // invalidated after reset
    probe(19'd0, 8'd0, "R1");          // nothing can hit

    // R2: masking of the tag register
    set_ehi(32'hFFFF_FFFF, 2'd0, "R2");
    set_ehi(32'hFFFF_FFFF, 2'd1, "R2");
    set_ehi(32'hFFFF_FFFF, 2'd2, "R2");
    set_ehi(32'h1234_5F5A, 2'd3, "R2");

    // R4: fill entries 0..7
    for (int i = 0; i < 8; i++) begin
      logic [25:0] l0, l1;
      l0 = {20'hA0000 + 20'(i), 3'(i), 1'b1, 1'b1, 1'b0};
      l1 = {20'hB0000 + 20'(i), 3'(7 - i), 1'b0, 1'b1, 1'b0};
      if (i == 2) begin l0[0] = 1; l1[0] = 1; end
      if (i == 6) begin l0[0] = 1; l1[0] = 0; end
      write_entry(5'(i), 19'h100 + 19'(i), (i < 4) ? 8'h05 : 8'h09, l0, l1, 0, "R4");
    end
    write_entry(5'd10, 19'h104, 8'h09, 26'h3FFFFFE, 26'h0000040, 0, "R4");
    do_cmd(3'd2, 5'd0, "R4");
    do_cmd(3'd2, 5'd2, "R4");           // global entry
    do_cmd(3'd2, 5'd6, "R4");           // only one half global: G=0
    do_cmd(3'd2, 5'd10, "R4");
    do_cmd(3'd2, 5'd15, "R5");          // never written

    // R6 / R7: probes
    probe(19'h101, 8'h05, "R6");
    probe(19'h102, 8'h09, "R6");        // global entry matches any ASID
    probe(19'h101, 8'h09, "R7");        // miss, index holds
    probe(19'h104, 8'h09, "R6");        // entries 4 and 10: lowest wins
    probe(19'h1FF, 8'h05, "R7");

    // R3: write with flag set
    write_entry(5'd1, 19'h1AA, 8'h33, 26'h3FFFFFF, 26'h3FFFFFF, 1, "R3");
    do_cmd(3'd2, 5'd1, "R3");
    probe(19'h101, 8'h05, "R3");
    probe(19'h1AA, 8'h33, "R3");

    // R11: out-of-range index
    do_cmd(3'd2, 5'd3, "R11");
    write_entry(5'd20, 19'h1EE, 8'h05, 26'h1555555, 26'h2AAAAAA, 0, "R11");
    probe(19'h1EE, 8'h05, "R11");
    do_cmd(3'd2, 5'd20, "R11");         // outputs hold previous read
    do_cmd(3'd2, 5'd31, "R11");

    // R8: invalidate by ASID 5; tag register page differs from every entry
    set_ehi({19'h7FFFF, 5'd0, 8'h05}, 2'd2, "R2");
    do_cmd(3'd4, 5'd0, "R8");
    do_cmd(3'd2, 5'd0, "R8");
    do_cmd(3'd2, 5'd3, "R8");
    do_cmd(3'd2, 5'd2, "R8");           // global survives
    do_cmd(3'd2, 5'd4, "R8");           // other ASID survives
    probe(19'h100, 8'h05, "R8");
    probe(19'h102, 8'h05, "R8");

    // R12: unused codes
    illegal_op(3'd0);
    illegal_op(3'd6);
    illegal_op(3'd7);

    // R9: invalidate everything
    do_cmd(3'd5, 5'd0, "R9");
    do_cmd(3'd2, 5'd2, "R9");
    do_cmd(3'd2, 5'd10, "R9");
    probe(19'h102, 8'h00, "R9");
    probe(19'h104, 8'h09, "R9");

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R10", "pending results", sb_q.size(), 32'd0);
    finish_run();
  end

endmodule